// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous memory that serves four-beat bursts. On a load cycle with the chip selected it captures an external start address and a read/write direction. On each advance cycle after that it steps the two low address bits through a four-beat sequence and leaves the upper bits unchanged. A static mode input picks the step order. Linear order counts up modulo four. Interleaved order XORs the start bits with the beat number.

The sequence keeps wrapping for as long as advance stays asserted. A load cycle taken while the chip is deselected stops the burst. A suspend input freezes all state, so the clock edge behaves as if it never happened. The outputs are registered. The address, a beat-valid flag and a write flag are presented to the memory core one cycle after the control inputs are sampled.

Top module: `burst_addr_seq`

## Requirements
- R1: A rising edge with `stall`=0, `adv`=0 and `sel`=1 captures `addr_in` and `wr_in`. After that edge `addr_out` equals the captured address, `beat_valid`=1 and `beat_write` equals the captured `wr_in`.
- R2: On an edge with `stall`=0 and `adv`=1, `addr_in` is ignored. Bits [ADDR_W-1:2] of `addr_out` do not change.
- R3: With `interleave`=0, the k-th advance after a load gives low bits `addr_out[1:0]` = (start + k) mod 4. Start 2 gives 2, 3, 0, 1.
- R4: With `interleave`=1, the k-th advance gives `addr_out[1:0]` = start XOR (k mod 4). Start 1 gives 1, 0, 3, 2.
- R5: After the fourth beat the sequence wraps to the start value and keeps repeating while advances continue.
- R6: An edge with `stall`=0, `adv`=0 and `sel`=0 ends any burst and clears `beat_valid`. Later advance edges with no burst active keep `beat_valid`=0 and leave `addr_out` unchanged.
- R7: On an edge with `stall`=1, `addr_out`, `beat_valid` and `beat_write` all keep their values. The burst position is also kept, so the sequence resumes where it stopped.
- R8: After reset, `addr_out`=0, `beat_valid`=0 and `beat_write`=0.
- R9: During advance edges `wr_in` is ignored. `beat_write` keeps the direction captured at the load, and `beat_valid`=1 for every advance within an active burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Suspend: 1 freezes all state on this edge |
| sel | input | 1 | Chip selected (all enables true) |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| wr_in | input | 1 | Direction on a load: 1 = write, 0 = read |
| interleave | input | 1 | Static order: 1 = interleaved, 0 = linear |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current beat address to the memory core |
| beat_valid | output | 1 | A memory access is due this cycle |
| beat_write | output | 1 | Direction of the current access |

## Verification
Every output is due one rising edge after the control inputs that cause it are sampled. No result is combinational from the inputs, except that the low address bits follow the static `interleave` input.

The bench drives inputs on the falling edge. Its behavioural model updates at the rising edge from the values it applied, and the outputs are compared with the model at the following falling edge. Each check therefore lands exactly one edge after its stimulus. Suspended edges are compared in the same way, so a held value is checked in the cycle it must persist.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              sel,
  input  logic              adv,
  input  logic              wr_in,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              beat_valid,
  output logic              beat_write
);
  localparam int LOW_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [LOW_W-1:0]  idx_q;
  logic              active_q;
  logic              valid_q;
  logic              write_q;

  wire do_load = !stall && !adv && sel;
  wire do_stop = !stall && !adv && !sel;
  wire do_step = !stall && adv && active_q;
  wire do_idle = !stall && adv && !active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      valid_q  <= 1'b0;
      write_q  <= 1'b0;
    end else if (do_load) begin
      base_q   <= addr_in;
      idx_q    <= '0;
      active_q <= 1'b1;
      valid_q  <= 1'b1;
      write_q  <= wr_in;
    end else if (do_stop) begin
      active_q <= 1'b0;
      valid_q  <= 1'b0;
    end else if (do_step) begin
      idx_q   <= idx_q + 1'b1;
      valid_q <= 1'b1;
    end else if (do_idle) begin
      valid_q <= 1'b0;
    end
  end

  logic [LOW_W-1:0] low_lin, low_ilv;
  assign low_lin = base_q[LOW_W-1:0] + idx_q;
  assign low_ilv = base_q[LOW_W-1:0] ^ idx_q;

  assign addr_out   = {base_q[ADDR_W-1:LOW_W], interleave ? low_ilv : low_lin};
  assign beat_valid = valid_q;
  assign beat_write = write_q;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && sel) |=> (beat_valid && beat_write == $past(wr_in)
                                 && base_q == $past(addr_in))); // R1
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv) |=> addr_out[ADDR_W-1:LOW_W] == $past(addr_out[ADDR_W-1:LOW_W])); // R2
  AST_DESELECT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !adv && !sel) |=> !beat_valid); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(beat_valid) && $stable(beat_write) && $stable(base_q)
               && $stable(idx_q))); // R7
  AST_DIR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && adv) |=> $stable(beat_write)); // R9
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0, sel = 1'b0, adv = 1'b1, wr_in = 1'b0, interleave = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic beat_valid, beat_write;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sel(sel), .adv(adv),
    .wr_in(wr_in), .interleave(interleave), .addr_in(addr_in),
    .addr_out(addr_out), .beat_valid(beat_valid), .beat_write(beat_write));

  always #10 clk = ~clk;

  int vectors = 0, errors = 0;
  logic [AW-1:0] m_base = '0;
  int m_beat = 0;
  bit m_active = 0, m_valid = 0, m_wr = 0;

  function automatic logic [AW-1:0] model_addr();
    int s, l;
    s = int'(m_base[1:0]);
    if (interleave) l = s ^ (m_beat % 4);
    else l = (s + m_beat) % 4;
    return (m_base & ~(AW'(3))) | AW'(l);
  endfunction

  task automatic compare(string tag);
    logic [AW-1:0] ea;
    ea = model_addr();
    vectors++;
    if (addr_out !== ea || beat_valid !== m_valid || beat_write !== m_wr) begin
      errors++;
      $display("FAIL %s: addr=%h valid=%b write=%b expected addr=%h valid=%b write=%b",
               tag, addr_out, beat_valid, beat_write, ea, m_valid, m_wr);
    end
  endtask

  task automatic cyc(bit st, bit sl, bit ad, bit wr, logic [AW-1:0] a, string tag);
    stall = st; sel = sl; adv = ad; wr_in = wr; addr_in = a;
    @(posedge clk);
    if (!st) begin
      if (!ad) begin
        if (sl) begin
          m_base = a; m_beat = 0; m_active = 1; m_wr = wr; m_valid = 1;
        end else begin
          m_active = 0; m_valid = 0;
        end
      end else if (m_active) begin
        m_beat++; m_valid = 1;
      end else m_valid = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R8 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R8 idle after reset");

    // linear, start low bits 2, wraps twice, address pins and wr toggled
    interleave = 1'b0;
    cyc(0, 1, 0, 0, 17'h1A5A6, "R1 load read");
    for (int k = 0; k < 9; k++)
      cyc(0, k % 2, 1, k % 2, AW'(k * 4099 + 7), "R3 R5 R2 R9 linear advance");

    // write burst with suspend in the middle
    cyc(0, 1, 0, 1, 17'h0F0F1, "R1 load write");
    cyc(0, 1, 1, 0, 17'h1FFFF, "R3 R9 advance");
    cyc(1, 1, 1, 0, 17'h12345, "R7 stall on advance");
    cyc(1, 1, 0, 0, 17'h00002, "R7 stall on load");
    cyc(0, 1, 1, 0, 17'h0, "R7 resume advance");
    cyc(0, 1, 1, 0, 17'h0, "R3 advance");

    // deselect ends burst
    cyc(0, 0, 0, 1, 17'h1AAAA, "R6 deselect");
    cyc(0, 1, 1, 1, 17'h15555, "R6 advance without burst");
    cyc(0, 1, 1, 0, 17'h00003, "R6 advance without burst");
    cyc(1, 0, 0, 0, 17'h0, "R7 stall while idle");

    // interleaved, every start value
    interleave = 1'b1;
    for (int s = 0; s < 4; s++) begin
      cyc(0, 1, 0, s % 2, AW'(17'h0C840 | s), "R1 load interleaved");
      for (int k = 0; k < 6; k++)
        cyc(0, 1, 1, ~(s % 2), AW'(k * 311), "R4 R5 interleaved advance");
    end

    // linear, every start value, back-to-back loads
    interleave = 1'b0;
    for (int s = 0; s < 4; s++) begin
      cyc(0, 1, 0, 1, AW'(17'h13370 | s), "R1 back-to-back load");
      for (int k = 0; k < 5; k++)
        cyc(0, 1, 1, 0, AW'(k), "R3 R5 linear advance");
    end
    cyc(0, 1, 0, 0, 17'h00001, "R1 load");
    cyc(0, 1, 0, 1, 17'h00002, "R1 load replaces load");
    cyc(1, 1, 1, 0, 17'h0, "R7 stall");
    cyc(0, 0, 0, 0, 17'h0, "R6 deselect");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule